// File: doc/BRIEF.md
# Low-Power Clock Hold Controller

This block derives the internal processor clock `phi` from a raw oscillator and manages two low-power states of a small 8-bit controller. A stop command parks `phi` high and tells the analog oscillator to shut down through `osc_en`. A wait command parks `phi` high but leaves the oscillator running. A mode command is taken only while the clock runs. It takes effect at the end of the current `phi` period, so `phi` never shows a short pulse. The divider ratio follows a select bit and changes only at a period boundary.

An interrupt request ends either low-power state, but only if the interrupt enable was set when the command arrived. Waking from the wait state restarts `phi` at once. Waking from the stop state turns the oscillator back on. `phi` then stays high while two cascaded 8-bit down-counters, fed by an oscillator/16 tick and loaded from reload registers when the stop state was entered, run out. When the upper counter underflows, `wake_uf` pulses for one cycle and the clock is released. Reset brings the oscillator back in any state and holds `phi` high for a fixed, parameterised number of oscillator/16 ticks.

The controller has five states. RUN is the normal running state. WAIT is the wait hold. STOP is the stop hold with the oscillator off. OSC_WARM is the timed recovery after an interrupt wakes the block from STOP. RST_WARM is the timed recovery after reset. The named transitions are:
- enter_wait: RUN to WAIT.
- enter_stop: RUN to STOP.
- wait_wake: WAIT to RUN.
- stop_wake: STOP to OSC_WARM.
- timer_release: OSC_WARM to RUN.
- stab_release: RST_WARM to RUN.
- Reset from any state leads to RST_WARM.

Top module: `clk_hold_ctrl`

## Requirements
- R1: During reset, `osc_en`=1, `phi`=1 and `wake_uf`=0. After reset is released, `phi` stays high through STAB_TICKS oscillator/16 ticks, which is 16*STAB_TICKS cycles. With a /2 ratio, the first low `phi` appears in cycle 16*STAB_TICKS+1 after release.
- R2: `div_sel`=0 gives `phi` a 2-cycle period: 1 cycle high, then 1 low. `div_sel`=1 gives a 4-cycle period: 2 high, then 2 low. Every period starts high, and a new ratio applies from the next period start.
- R3: A `stop_cmd` pulse in RUN drives `osc_en` to 0 within one `phi` period, with `phi` at 1. While `osc_en` is 0, `phi` is 1.
- R4: When STOP is woken by an armed `irq_req`, `osc_en` returns to 1 on the next edge. `phi` stays high until 16*(A+1)*(B+1) cycles after the wake edge, where A and B are the reload values in force when the stop was entered.
- R5: `wake_uf` is 1 for exactly one cycle, in the cycle in which the clock is released after a stop wake.
- R6: A `wait_cmd` pulse in RUN parks `phi` at 1 within one period, and `osc_en` stays at 1.
- R7: An armed `irq_req` in WAIT restarts `phi` with no delay. The first low `phi` comes 1+N/2 cycles after the wake edge, where N is the divider ratio.
- R8: `irq_en` is sampled with the command. If it was 0, a later `irq_req` leaves the block in its low-power state even if `irq_en` rises afterwards.
- R9: Reset during STOP ends it and applies the same fixed hold as R1.
- R10: Mode entry waits for the end of the current `phi` period, so every low phase of `phi` before a hold lasts its full N/2 cycles.
- R11: If `stop_cmd` and `wait_cmd` arrive together, the block enters STOP.
- R12: The reload values are captured on entry to STOP. Changing `t1_reload` or `t2_reload` during STOP has no effect on the wake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_cmd | input | 1 | One-cycle stop request |
| wait_cmd | input | 1 | One-cycle wait request |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable, sampled with a command |
| div_sel | input | 1 | 0 selects /2 and 1 selects /4 for `phi` |
| t1_reload | input | TMR_W | Reload value for the lower wake counter |
| t2_reload | input | TMR_W | Reload value for the upper wake counter |
| phi | output | 1 | Internal clock, parked high when held |
| osc_en | output | 1 | Oscillator enable, 0 in STOP only |
| wake_uf | output | 1 | One-cycle upper-counter underflow flag |

## Verification
Every result has a fixed cycle position measured from the edge that samples the stimulus. The stop wake releases at 16*(A+1)*(B+1), the reset hold at 16*STAB_TICKS, a wait wake shows its first low phase at 1+N/2, and stop entry lands within N cycles. The bench drives inputs and samples outputs on falling edges. It counts samples from the sampling edge and compares each count with the arithmetic formula. It sweeps a grid of reload values, both ratios, and every command phase within a `phi` period.

// File: rtl/clk_hold_pkg.sv
package clk_hold_pkg;

    typedef enum logic [2:0] {
        CH_RUN,
        CH_WAIT,
        CH_STOP,
        CH_OSC_WARM,
        CH_RST_WARM
    } ch_state_e;

endpackage

// File: rtl/ch_prescaler.sv
module ch_prescaler #(
    parameter int LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    logic [LOG2-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = &cnt_q;

endmodule

// File: rtl/ch_cascade.sv
module ch_cascade #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] rl1,
    input  logic [W-1:0] rl2,
    output logic         uf
);
    logic [W-1:0] lat1_q, lat2_q, t1_q, t2_q;
    logic         step;

    assign step = run && tick;
    assign uf   = step && (t1_q == '0) && (t2_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat1_q <= '0;
            lat2_q <= '0;
            t1_q   <= '0;
            t2_q   <= '0;
        end else if (load) begin
            lat1_q <= rl1;
            lat2_q <= rl2;
            t1_q   <= rl1;
            t2_q   <= rl2;
        end else if (step) begin
            if (t1_q == '0) begin
                t1_q <= lat1_q;
                if (t2_q == '0) begin
                    t2_q <= lat2_q;
                end else begin
                    t2_q <= t2_q - 1'b1;
                end
            end else begin
                t1_q <= t1_q - 1'b1;
            end
        end
    end

    // R4: counters only move on a timed tick or a load
    p_timers_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(t1_q) && $stable(t2_q)));

    // R4: the upper counter moves only when the lower one underflows
    p_upper_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && t1_q != '0) |=> $stable(t2_q));

endmodule

// File: rtl/ch_stab_cnt.sv
module ch_stab_cnt #(
    parameter int W     = 16,
    parameter int TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam logic [W-1:0] START = W'(TICKS);
    localparam logic [W-1:0] ONE   = W'(1);

    logic [W-1:0] cnt_q;

    assign done = run && tick && (cnt_q <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= START;
        end else if (run && tick && cnt_q > ONE) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // R1: the hold counter moves only on a tick
    p_stab_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) |=> $stable(cnt_q));

endmodule

// File: rtl/ch_phi_div.sv
module ch_phi_div #(
    parameter int DIV_LO = 2,
    parameter int DIV_HI = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic div_sel,
    output logic phi,
    output logic last
);
    localparam int PW = $clog2(DIV_HI);
    localparam logic [PW:0] RATIO_LO = (PW+1)'(DIV_LO);
    localparam logic [PW:0] RATIO_HI = (PW+1)'(DIV_HI);
    localparam logic [PW:0] ONE      = (PW+1)'(1);

    logic [PW:0] ph_q, ratio, half, ph_nxt;
    logic        sel_q, phi_q;

    assign ratio  = sel_q ? RATIO_HI : RATIO_LO;
    assign half   = ratio >> 1;
    assign ph_nxt = ph_q + ONE;
    assign last   = (ph_q == ratio - ONE);
    assign phi    = phi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= '0;
            sel_q <= 1'b0;
            phi_q <= 1'b1;
        end else if (hold || last) begin
            ph_q  <= '0;
            sel_q <= div_sel;
            phi_q <= 1'b1;
        end else begin
            ph_q  <= ph_nxt;
            phi_q <= (ph_nxt < half);
        end
    end

    // R10: a held clock is always parked high
    p_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> phi_q);

    // R2: phase stays inside the selected period
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (ph_q < ratio));

endmodule

// File: rtl/clk_hold_ctrl.sv
module clk_hold_ctrl
    import clk_hold_pkg::*;
#(
    parameter int PSC_LOG2   = 4,
    parameter int TMR_W      = 8,
    parameter int STAB_W     = 16,
    parameter int STAB_TICKS = 1024,
    parameter int DIV_LO     = 2,
    parameter int DIV_HI     = 4
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             stop_cmd,
    input  logic             wait_cmd,
    input  logic             irq_req,
    input  logic             irq_en,
    input  logic             div_sel,
    input  logic [TMR_W-1:0] t1_reload,
    input  logic [TMR_W-1:0] t2_reload,
    output logic             phi,
    output logic             osc_en,
    output logic             wake_uf
);
    ch_state_e state_q, state_d;
    logic stop_pend_q, wait_pend_q, arm_q, arm_d, uf_q;
    logic go_stop, go_wait, wake_ok;
    logic hold, last, tick, psc_clr, tmr_load, tmr_run, tmr_uf, stab_run, stab_done;

    assign go_stop = stop_pend_q || stop_cmd;
    assign go_wait = wait_pend_q || wait_cmd;
    assign arm_d   = (stop_cmd || wait_cmd) ? irq_en : arm_q;
    assign wake_ok = irq_req && arm_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_RUN: begin
                if (last) begin
                    if (go_stop)      state_d = CH_STOP;   // enter_stop
                    else if (go_wait) state_d = CH_WAIT;   // enter_wait
                end
            end
            CH_WAIT:     if (wake_ok)   state_d = CH_RUN;       // wait_wake
            CH_STOP:     if (wake_ok)   state_d = CH_OSC_WARM;  // stop_wake
            CH_OSC_WARM: if (tmr_uf)    state_d = CH_RUN;       // timer_release
            CH_RST_WARM: if (stab_done) state_d = CH_RUN;       // stab_release
            default:                    state_d = CH_RST_WARM;
        endcase
    end

    // state register and mode latches
    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= CH_RST_WARM;
            stop_pend_q <= 1'b0;
            wait_pend_q <= 1'b0;
            arm_q       <= 1'b0;
            uf_q        <= 1'b0;
        end else begin
            state_q <= state_d;
            uf_q    <= tmr_uf;
            if (state_q == CH_RUN) begin
                arm_q <= arm_d;
                if (state_d != CH_RUN) begin
                    stop_pend_q <= 1'b0;
                    wait_pend_q <= 1'b0;
                end else begin
                    if (stop_cmd) stop_pend_q <= 1'b1;
                    if (wait_cmd) wait_pend_q <= 1'b1;
                end
            end
        end
    end

    // outputs and sub-block controls
    always_comb begin
        hold     = (state_q != CH_RUN);
        osc_en   = (state_q != CH_STOP);
        tmr_load = (state_q == CH_RUN) && (state_d == CH_STOP);
        tmr_run  = (state_q == CH_OSC_WARM);
        psc_clr  = (state_q == CH_STOP) && (state_d == CH_OSC_WARM);
        stab_run = (state_q == CH_RST_WARM);
        wake_uf  = uf_q;
    end

    ch_prescaler #(.LOG2(PSC_LOG2)) u_psc (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .clr   (psc_clr),
        .tick  (tick)
    );

    ch_cascade #(.W(TMR_W)) u_tmr (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .tick  (tick),
        .rl1   (t1_reload),
        .rl2   (t2_reload),
        .uf    (tmr_uf)
    );

    ch_stab_cnt #(.W(STAB_W), .TICKS(STAB_TICKS)) u_stab (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .run   (stab_run),
        .tick  (tick),
        .done  (stab_done)
    );

    ch_phi_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .hold    (hold),
        .div_sel (div_sel),
        .phi     (phi),
        .last    (last)
    );

    // R3: oscillator off implies a parked-high clock
    p_osc_off_phi_high_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !osc_en |-> phi);

    // R4: stop hold is left only through the timed warm-up
    p_stop_exit_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (state_q == CH_STOP) |=> (state_q == CH_STOP || state_q == CH_OSC_WARM));

    // R5: underflow flag is a single pulse at release
    p_uf_single_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        wake_uf |=> !wake_uf);
    p_uf_release_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        wake_uf |-> (state_q == CH_RUN));

    // R7: wait wake has no delay
    p_wait_wake_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (state_q == CH_WAIT && irq_req && arm_q) |=> (state_q == CH_RUN));

    // R8: an unarmed low-power state is not left by interrupt
    p_unarmed_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ((state_q == CH_STOP || state_q == CH_WAIT) && !arm_q) |=> $stable(state_q));

endmodule

// File: tb/clk_hold_ctrl_test.sv
`timescale 1ns/1ps
module clk_hold_ctrl_test;
    localparam int T = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_cmd = 1'b0, wait_cmd = 1'b0, irq_req = 1'b0, irq_en = 1'b0, div_sel = 1'b0;
    logic [7:0] t1_reload = 8'd0, t2_reload = 8'd0;
    logic       phi, osc_en, wake_uf;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clk_hold_ctrl #(.STAB_TICKS(T)) uut (
        .clk_osc(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .wait_cmd(wait_cmd),
        .irq_req(irq_req), .irq_en(irq_en), .div_sel(div_sel),
        .t1_reload(t1_reload), .t2_reload(t2_reload),
        .phi(phi), .osc_en(osc_en), .wake_uf(wake_uf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reset, then count samples until phi first goes low (div /2)
    task automatic reset_hold(input string tag);
        int n;
        rst_n = 1'b0; stop_cmd = 0; wait_cmd = 0; irq_req = 0; div_sel = 0;
        repeat (3) @(negedge clk);
        chk({tag, " osc_en in reset"}, osc_en, 1);
        chk({tag, " phi in reset"}, phi, 1);
        chk({tag, " wake_uf in reset"}, wake_uf, 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (phi && n < 2000);
        chk({tag, " first low after reset"}, n, 16*T+1);
    endtask

    task automatic sync_rise();
        logic prev;
        prev = phi;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!prev && phi) break;
            prev = phi;
        end
    endtask

    // issue a command at a given offset after a rising phi; check R10 low runs
    task automatic enter_mode(input bit s, input bit w, input bit en, input int off,
                              input int nrat, output int lat);
        int run, j, cmdj;
        sync_rise();
        run = 0; j = 0; cmdj = -1; lat = -1;
        while (j < 40) begin
            if (j == off) begin stop_cmd = s; wait_cmd = w; irq_en = en; cmdj = j; end
            @(negedge clk);
            j++;
            stop_cmd = 0; wait_cmd = 0;
            if (phi == 1'b0) run++;
            else begin
                if (run != 0) chk("R10 low phase length", run, nrat/2);
                run = 0;
            end
            if (s && !osc_en) begin lat = j - cmdj; break; end
            if (!s && j >= off + nrat + 1) begin lat = 0; break; end
        end
        chk("R10 phi high at hold start", phi, 1);
    endtask

    task automatic stop_wake(input int a, input int b, input string tag);
        int n;
        int bad_phi;
        irq_req = 1'b1;
        n = 0; bad_phi = 0;
        do begin
            @(negedge clk); n++; irq_req = 1'b0;
            if (n == 1) chk({tag, " R4 osc_en back"}, osc_en, 1);
            if (!wake_uf && !phi) bad_phi++;
        end while (!wake_uf && n < 5000);
        chk({tag, " R4 phi held during warm-up"}, bad_phi, 0);
        chk({tag, " R4 release cycle"}, n, 16*(a+1)*(b+1)+1);
        @(negedge clk);
        chk({tag, " R5 flag one cycle"}, wake_uf, 0);
    endtask

    initial begin
        int lat, n, bad;
        reset_hold("R1");

        // R2 ratio patterns
        for (int s = 1; s >= 0; s--) begin
            int nr;
            nr = (s == 1) ? 4 : 2;
            div_sel = s[0];
            repeat (6) @(negedge clk);
            sync_rise();
            bad = 0;
            for (int j = 1; j < 8; j++) begin
                @(negedge clk);
                if (phi != ((j % nr) < nr/2)) bad++;
            end
            chk($sformatf("R2 pattern ratio %0d", nr), bad, 0);
        end

        // R4 / R12 sweep of reload values, R3 entry latency
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 3; b++) begin
                int ra, rb;
                ra = (a == 3) ? 5 : a;
                rb = (b == 2) ? 3 : b;
                t1_reload = 8'(ra); t2_reload = 8'(rb);
                enter_mode(1, 0, 1, 0, 2, lat);
                chk("R3 stop entry within period", int'(lat >= 1 && lat <= 2), 1);
                t1_reload = 8'd7; t2_reload = 8'd7;   // R12: ignored after entry
                repeat (3) @(negedge clk);
                chk("R3 osc_en off", osc_en, 0);
                stop_wake(ra, rb, $sformatf("R12 rl=%0d/%0d", ra, rb));
            end
        end

        // R10 / R3 with ratio 4 at every command phase
        div_sel = 1'b1;
        t1_reload = 8'd0; t2_reload = 8'd0;
        for (int off = 0; off < 4; off++) begin
            enter_mode(1, 0, 1, off, 4, lat);
            chk($sformatf("R3 entry latency off %0d", off), int'(lat >= 1 && lat <= 4), 1);
            stop_wake(0, 0, "R10 ratio 4");
        end

        // R6 / R7 wait hold and immediate wake, both ratios
        for (int s = 0; s < 2; s++) begin
            int nr;
            nr = (s == 1) ? 4 : 2;
            div_sel = s[0];
            enter_mode(0, 1, 1, 1, nr, lat);
            bad = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!phi || !osc_en) bad++;
            end
            chk("R6 wait hold with oscillator on", bad, 0);
            irq_req = 1'b1;
            n = 0;
            do begin @(negedge clk); n++; irq_req = 1'b0; end while (phi && n < 100);
            chk($sformatf("R7 wait wake first low ratio %0d", nr), n, 1 + nr/2);
        end

        // R11 both commands at once -> stop
        div_sel = 1'b0;
        enter_mode(1, 1, 1, 0, 2, lat);
        chk("R11 stop wins", osc_en, 0);
        stop_wake(0, 0, "R11");

        // R8 unarmed stop, then R9 reset out of stop
        enter_mode(1, 0, 0, 0, 2, lat);
        irq_en = 1'b1;
        irq_req = 1'b1;
        bad = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (k == 2) irq_req = 1'b0;
            if (osc_en || !phi) bad++;
        end
        chk("R8 unarmed stop stays", bad, 0);
        reset_hold("R9");

        // R8 unarmed wait
        enter_mode(0, 1, 0, 0, 2, lat);
        irq_en = 1'b1; irq_req = 1'b1;
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!phi) bad++;
        end
        irq_req = 1'b0;
        chk("R8 unarmed wait stays", bad, 0);
        reset_hold("R1 again");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule